// File: doc/BRIEF.md
# Oversampling UART Receiver with Majority-Vote Bit Decision

This block receives asynchronous serial frames of ten bits: a low start bit, eight data bits with the least significant bit first, and a high stop bit. It samples the serial line once on each pulse of a tick that runs at sixteen times the baud rate. The first tick that sees a 1-to-0 transition while the receiver is idle and enabled becomes slice 0 of the start bit. This restarts the sixteen-slice bit counter, so that bit boundaries follow the incoming edge rather than a free-running count.

The serial input passes through a two-flop synchronizer first. Each bit is then decided by a two-of-three vote over the samples in slices 8, 9 and 10. A start bit that votes high counts as a glitch, and the receiver goes back to looking for an edge.

At the last slice of the stop bit, the receiver loads the assembled byte and the voted stop bit into their output registers and sets a completion flag. The flag stays set until a clear pulse arrives. When a new frame completes on the same cycle as a clear, the completion wins. Dropping the enable abandons any frame in progress.

Top module: `uart_mv_rx`

## Requirements
- R1: After reset, rx_done, rx_stop and rx_data are all 0.
- R2: A frame is a 0 start bit, eight data bits with bit 0 sent first, and a stop bit. The eight voted data bits appear on rx_data in bit order.
- R3: Each bit is the majority of the synchronized line sampled at slices 8, 9 and 10 of that bit. Slice 0 is the tick on which the start edge was detected. A single deviating sample among the three does not change the result.
- R4: A frame starts only when the receiver is idle and rx_en is high, on a tick where the synchronized line is 0 and the sample from the previous tick was 1. The slice counter restarts at that tick.
- R5: If the start bit votes 1, the frame is discarded, nothing is loaded, and the receiver returns to edge search.
- R6: The voted stop bit is placed on rx_stop. A frame whose stop bit votes 0 is still loaded, with rx_stop = 0.
- R7: On the tick of slice 15 of the stop bit, rx_data and rx_stop are loaded and rx_done rises one clock later. rx_done then stays 1 until it is cleared.
- R8: A one-cycle rx_clr pulse clears rx_done. If a load occurs on the same cycle as rx_clr, rx_done stays 1.
- R9: While rx_en is 0, no frame is started or completed. A frame in progress when rx_en falls is abandoned, and rx_done, rx_data and rx_stop are left unchanged.
- R10: rx_in passes through a two-stage synchronizer before edge detection and voting.
- R11: rx_data and rx_stop change only when a frame is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | One-cycle enable pulse at 16x the baud rate |
| rx_en | input | 1 | Receive enable |
| rx_in | input | 1 | Asynchronous serial input, idle high |
| rx_clr | input | 1 | Clears the completion flag |
| rx_data | output | 8 | Last received byte |
| rx_stop | output | 1 | Voted stop bit of the last received frame |
| rx_done | output | 1 | Completion flag, held until cleared |

## Verification
The assertions check the following on every cycle: the completion flag holds until it is cleared, a clear works unless a load coincides with it, loads only happen on a tick and are always followed by the flag, rx_en low prevents any load on the next cycle, and the byte and stop outputs hold between loads.

Some behaviours only the bench's frame scenarios can show. These are the bit ordering, the vote rejecting a single glitch in slice 9 on both the start and a data bit, the rejection of a false start, the capture of a zero stop bit, the load-beats-clear case, and recovery after an aborted frame.

// File: rtl/mvrx_pkg.sv
package mvrx_pkg;
  typedef enum logic {
    RX_IDLE = 1'b0,
    RX_BUSY = 1'b1
  } rx_state_t;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/mvrx_sync.sv
module mvrx_sync #(
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/mvrx_vote.sv
module mvrx_vote
  import mvrx_pkg::*;
#(
  parameter int CW = 4,
  parameter int FIRST = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [CW-1:0] slice,
  input  logic          din,
  output logic          vote_stb,
  output logic          vote_bit
);
  localparam logic [CW-1:0] SL_A = CW'(FIRST);
  localparam logic [CW-1:0] SL_B = CW'(FIRST + 1);
  localparam logic [CW-1:0] SL_C = CW'(FIRST + 2);

  logic smp_a, smp_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_a <= 1'b1;
      smp_b <= 1'b1;
    end else if (tick) begin
      if (slice == SL_A) smp_a <= din;
      if (slice == SL_B) smp_b <= din;
    end
  end

  assign vote_stb = tick && (slice == SL_C);
  assign vote_bit = maj3(smp_a, smp_b, din);
endmodule

// File: rtl/uart_mv_rx.sv
module uart_mv_rx
  import mvrx_pkg::*;
#(
  parameter int DW = 8,
  parameter int OSR = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick16,
  input  logic          rx_en,
  input  logic          rx_in,
  input  logic          rx_clr,
  output logic [DW-1:0] rx_data,
  output logic          rx_stop,
  output logic          rx_done
);
  localparam int CW = $clog2(OSR);
  localparam int FRAME_BITS = DW + 2;
  localparam int BW = $clog2(FRAME_BITS);
  localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS - 1);
  localparam logic [CW-1:0] LAST_SLICE = CW'(OSR - 1);

  rx_state_t     st;
  logic          rx_s;
  logic          prev_smp;
  logic [CW-1:0] phase;
  logic [CW-1:0] cur_slice;
  logic [BW-1:0] bidx;
  logic [DW-1:0] shreg;
  logic          stop_vote;
  logic          vote_stb, vote_bit;
  logic          start_det, load_s;

  mvrx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .din(rx_in), .dout(rx_s)
  );

  assign cur_slice = phase + CW'(1);

  mvrx_vote #(.CW(CW), .FIRST(OSR / 2)) u_vote (
    .clk(clk), .rst(rst),
    .tick(tick16 && rx_en && (st == RX_BUSY)),
    .slice(cur_slice), .din(rx_s),
    .vote_stb(vote_stb), .vote_bit(vote_bit)
  );

  assign start_det = tick16 && rx_en && (st == RX_IDLE) && prev_smp && !rx_s;
  assign load_s    = tick16 && rx_en && (st == RX_BUSY) &&
                     (bidx == LAST_BIT) && (cur_slice == LAST_SLICE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= RX_IDLE;
      prev_smp  <= 1'b1;
      phase     <= '0;
      bidx      <= '0;
      shreg     <= '0;
      stop_vote <= 1'b1;
    end else begin
      if (tick16) prev_smp <= rx_s;
      case (st)
        RX_IDLE: begin
          if (start_det) begin
            st    <= RX_BUSY;
            phase <= '0;
            bidx  <= '0;
          end
        end
        RX_BUSY: begin
          if (!rx_en) begin
            st <= RX_IDLE;
          end else if (tick16) begin
            phase <= cur_slice;
            if (vote_stb) begin
              if (bidx == '0) begin
                if (vote_bit) st <= RX_IDLE;
              end else if (bidx == LAST_BIT) begin
                stop_vote <= vote_bit;
              end else begin
                shreg <= {vote_bit, shreg[DW-1:1]};
              end
            end
            if (cur_slice == LAST_SLICE) begin
              if (bidx == LAST_BIT) st <= RX_IDLE;
              else                  bidx <= bidx + BW'(1);
            end
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data <= '0;
      rx_stop <= 1'b0;
      rx_done <= 1'b0;
    end else begin
      if (load_s) begin
        rx_data <= shreg;
        rx_stop <= stop_vote;
        rx_done <= 1'b1;
      end else if (rx_clr) begin
        rx_done <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mvrx_chk.sv
module mvrx_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          tick16,
  input logic          rx_en,
  input logic          rx_clr,
  input logic          load,
  input logic [DW-1:0] rx_data,
  input logic          rx_stop,
  input logic          rx_done
);
  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_done && !rx_clr) |=> rx_done);

  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_clr && !load) |=> !rx_done);

  // R8
  load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> rx_done);

  // R7
  load_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    load |-> tick16);

  // R9
  no_load_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> !load);

  // R11
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(rx_data) && $stable(rx_stop)));
endmodule

bind uart_mv_rx mvrx_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .tick16(tick16), .rx_en(rx_en), .rx_clr(rx_clr),
  .load(load_s), .rx_data(rx_data), .rx_stop(rx_stop), .rx_done(rx_done)
);

// File: tb/test_uart_mv_rx.sv
module test_uart_mv_rx;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick16 = 1'b0;
  logic       rx_en = 1'b1;
  logic       rx_in = 1'b1;
  logic       rx_clr = 1'b0;
  logic [7:0] rx_data;
  logic       rx_stop;
  logic       rx_done;

  int errors = 0;
  int checks = 0;
  logic [1:0] ph = 2'd0;
  logic [8:0] exp_q[$];
  logic       done_q = 1'b0;

  always #4 clk = ~clk;

  // tick every 4 clocks, driven away from the active edge
  always @(negedge clk) begin
    ph     <= ph + 2'd1;
    tick16 <= (ph == 2'd3);
  end

  uart_mv_rx i_uart_mv_rx (
    .clk(clk), .rst(rst), .tick16(tick16), .rx_en(rx_en), .rx_in(rx_in),
    .rx_clr(rx_clr), .rx_data(rx_data), .rx_stop(rx_stop), .rx_done(rx_done)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: every completion pops one expected item
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && rx_done && !done_q) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5/R9 unexpected completion", {23'd0, rx_stop, rx_data}, 32'd0);
        end else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          chk({rx_stop, rx_data} == e, "R2/R3/R6 frame content", {23'd0, rx_stop, rx_data}, {23'd0, e});
        end
      end
      done_q = rx_done;
    end
  end

  // drives one frame; index k is the k-th negedge after alignment to a tick
  task automatic send_frame(input logic [7:0] d, input logic stopv, input int gbit,
                            input bit abort, input bit clr_end, input bit expect_it);
    if (expect_it) exp_q.push_back({stopv, d});
    do @(negedge clk); while (ph != 2'd3);
    for (int k = 0; k < 640; k++) begin
      int b, c;
      logic v;
      if (k > 0) @(negedge clk);
      b = k / 64;
      c = k % 64;
      if (b == 0) v = 1'b0;
      else if (b == 9) v = stopv;
      else v = d[b-1];
      if (b == gbit && c >= 37 && c <= 39) v = ~v;
      rx_in = v;
      if (abort && k == 300) rx_en = 1'b0;
      if (abort && k == 304) rx_en = 1'b1;
    end
    @(negedge clk);
    rx_in = 1'b1;
    if (clr_end) rx_clr = 1'b1;
    @(negedge clk);
    rx_clr = 1'b0;
  endtask

  task automatic clear_flag();
    @(negedge clk);
    rx_clr = 1'b1;
    @(negedge clk);
    rx_clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 32'd0, 32'd1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(5);
    rst = 1'b0;
    idle(2);
    // R1 reset values
    chk(rx_done == 1'b0, "R1 done after reset", {31'd0, rx_done}, 32'd0);
    chk(rx_data == 8'h00, "R1 data after reset", {24'd0, rx_data}, 32'd0);
    chk(rx_stop == 1'b0, "R1 stop after reset", {31'd0, rx_stop}, 32'd0);
    idle(40);

    // R2 R4 R10 clean frame, LSB first
    send_frame(8'hA5, 1'b1, -1, 1'b0, 1'b0, 1'b1);
    idle(20);
    chk(rx_done == 1'b1, "R7 flag set after frame", {31'd0, rx_done}, 32'd1);
    idle(300);
    chk(rx_done == 1'b1, "R7 flag held without clear", {31'd0, rx_done}, 32'd1);
    clear_flag();
    chk(rx_done == 1'b0, "R8 clear drops flag", {31'd0, rx_done}, 32'd0);

    // R3 glitch at slice 9 of a data bit and of the start bit
    send_frame(8'h3C, 1'b1, 3, 1'b0, 1'b0, 1'b1);
    idle(40);
    clear_flag();
    send_frame(8'h81, 1'b1, 0, 1'b0, 1'b0, 1'b1);
    idle(40);
    clear_flag();
    send_frame(8'h5A, 1'b1, 9, 1'b0, 1'b0, 1'b1);
    idle(40);
    clear_flag();

    // R6 stop bit voting 0 still loads
    send_frame(8'hC3, 1'b0, -1, 1'b0, 1'b0, 1'b1);
    idle(80);
    chk(rx_stop == 1'b0, "R6 zero stop captured", {31'd0, rx_stop}, 32'd0);
    clear_flag();

    // R5 false start: line low for only 16 clocks
    do @(negedge clk); while (ph != 2'd3);
    rx_in = 1'b0;
    idle(16);
    rx_in = 1'b1;
    idle(800);
    chk(rx_done == 1'b0, "R5 false start ignored", {31'd0, rx_done}, 32'd0);
    chk(rx_data == 8'hC3, "R5 data kept after false start", {24'd0, rx_data}, 32'hC3);
    send_frame(8'h96, 1'b1, -1, 1'b0, 1'b0, 1'b1);
    idle(40);
    clear_flag();

    // R9 disabled receiver ignores a whole frame
    rx_en = 1'b0;
    send_frame(8'h11, 1'b1, -1, 1'b0, 1'b0, 1'b0);
    idle(80);
    chk(rx_done == 1'b0, "R9 no completion while disabled", {31'd0, rx_done}, 32'd0);
    chk(rx_data == 8'h96, "R9 data unchanged while disabled", {24'd0, rx_data}, 32'h96);
    rx_en = 1'b1;
    idle(40);

    // R9 abort mid-frame
    send_frame(8'hFF, 1'b1, -1, 1'b1, 1'b0, 1'b0);
    idle(800);
    chk(rx_done == 1'b0, "R9 aborted frame not loaded", {31'd0, rx_done}, 32'd0);
    chk(rx_data == 8'h96, "R9 data unchanged after abort", {24'd0, rx_data}, 32'h96);
    send_frame(8'h42, 1'b1, -1, 1'b0, 1'b0, 1'b1);
    idle(40);
    clear_flag();

    // R8 clear in the same cycle as the load: flag stays
    send_frame(8'h7E, 1'b1, -1, 1'b0, 1'b1, 1'b1);
    idle(4);
    chk(rx_done == 1'b1, "R8 load wins over clear", {31'd0, rx_done}, 32'd1);
    chk(rx_data == 8'h7E, "R11 data after last load", {24'd0, rx_data}, 32'h7E);

    idle(40);
    chk(exp_q.size() == 0, "R2 all expected frames received", exp_q.size(), 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule